// File: doc/BRIEF.md
# Flash Sector Address and Buffer Selection Generator

This block sits in front of a flash command engine and turns software-programmed address registers into the numbers that engine needs. Software writes eight 16-bit start-address registers and one buffer-control register over a simple register port. The block keeps those values and continuously presents a flat source sector index, a flat destination sector index (for copy-style commands), the first sector of the addressed erase block, a sector count, and the decoded buffer selection with its byte offsets in the main and spare areas.

The geometry is fixed at 2 KB pages of four 512-byte sectors and 64 pages per block. A block register carries a 12-bit block number plus a high-density extension flag at bit 15; when the device identifier advertises an extended part, that flag ORs a density mask into the block number. Data movement and command sequencing belong to the engine behind this block, not to it.

Top module: `sector_addr_gen`

## Requirements
- R1: After reset all eight start-address registers read 0, the buffer address is 0, the sector count is 1, and the buffer-control register (register address 8) reads 0.
- R2: Register addresses 0 to 7 are 16-bit read/write start-address registers that return exactly the last value written; register 1 is storage only and changes no output.
- R3: The source sector index is built from register 0 (block: bits 11:0 block number, bit 15 density flag, bits 14:12 ignored) and register 7 (bits 1:0 sector, bits 7:2 page, bits 15:8 ignored) as ((page + (block_value << 6)) << 2) + sector.
- R4: block_value is the 12-bit block number OR'ed with the density mask when bit 15 of the block register is set; the mask is 1 << (6 + dev_id[6:4]) when dev_id bit 3 is 1 and 0 otherwise.
- R5: The destination sector index uses the same rule with register 2 as the block and register 3 as the page/sector, and does not depend on registers 0 or 7.
- R6: The erase start sector equals the register 0 block_value shifted left by 8.
- R7: A write to register address 8 sets the buffer address to data bits 11:8 and the sector count to data bits 1:0, a count field of 0 giving a count of 4; all other data bits are ignored and the count is always 1 to 4.
- R8: Reading register address 8 returns (buffer address << 8) OR ((count - 1) AND 2).
- R9: Buffer address bit 3 set selects a data buffer (clear selects the boot buffer), bit 2 selects data buffer 0 or 1, and bits 1:0 give the main-area offset in 512-byte steps and the spare-area offset in 16-byte steps.
- R10: Every output reflects a register write from the clock edge that captures it onward and holds while no write occurs.
- R11: Register addresses 9 to 15 read 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Register address of the read |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| dev_id | input | 16 | Device identifier; bits 3 and 6:4 set the density mask |
| src_sector | output | 22 | Source sector index from registers 0 and 7 |
| dst_sector | output | 22 | Destination sector index from registers 2 and 3 |
| erase_sector | output | 22 | First sector of the block in register 0 |
| sec_count | output | 3 | Sector count, 1 to 4 |
| buf_addr | output | 4 | Stored buffer address |
| buf_is_data | output | 1 | 1 selects a data buffer, 0 the boot buffer |
| buf_data_sel | output | 1 | Which of the two data buffers |
| main_offset | output | 11 | Byte offset in the main area |
| spare_offset | output | 6 | Byte offset in the spare area |

## Verification
A register write is captured at one rising edge, and every derived output as well as the read-back value is due from that edge on, with no further register on the path; reads and the dev_id-driven density mask are purely combinational and due in the same cycle. The bench drives on the falling edge, lets exactly one rising edge pass for a write, and samples at the following falling edge, while read-backs and dev_id changes are sampled one nanosecond after the address or identifier is applied. Checks after ignored writes and after writes to unrelated registers sample the outputs at that same point, before any further stimulus.

// File: rtl/sag_pkg.sv
package sag_pkg;
    // Geometry and register-file defaults
    localparam int DEF_REG_W    = 16;
    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_ADDR_W   = 4;
    localparam int DEF_BLK_W    = 12;
    localparam int DEF_PAGE_W   = 6;
    localparam int DEF_SEC_W    = 2;
    localparam int DEF_DENS_W   = 3;
    localparam int DEF_BUFA_W   = 4;
    localparam int DEF_BUFA_LSB = 8;
    localparam int DEF_MAIN_SH  = 9;
    localparam int DEF_SPARE_SH = 4;

    // Register slots whose position the command engine relies on
    localparam int IDX_SRC_BLOCK = 0;
    localparam int IDX_DST_BLOCK = 2;
    localparam int IDX_DST_PAGE  = 3;
    localparam int IDX_SRC_PAGE  = 7;
    localparam int IDX_BUFCTL    = 8;

    function automatic int blkval_width(input int blk_w, input int page_w, input int dens_w);
        int ext;
        ext = page_w + (1 << dens_w);
        return (blk_w > ext) ? blk_w : ext;
    endfunction
endpackage

// File: rtl/sag_regfile.sv
module sag_regfile
    import sag_pkg::*;
#(
    parameter int REG_W    = DEF_REG_W,
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int BUFA_W   = DEF_BUFA_W,
    parameter int BUFA_LSB = DEF_BUFA_LSB,
    parameter int CNTF_W   = DEF_SEC_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [REG_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [REG_W-1:0]                 rd_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]   start_regs,
    output logic [BUFA_W-1:0]                bufa,
    output logic [CNTF_W:0]                  cnt
);
    localparam int CNT_W = CNTF_W + 1;
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] REGS_A   = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] BUFCTL_A = ADDR_W'(IDX_BUFCTL);
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(1 << CNTF_W);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] start;
        logic [BUFA_W-1:0]              bufa;
        logic [CNT_W-1:0]               cnt;
    } rf_state_t;

    localparam rf_state_t ST_RST = '{start: '0, bufa: '0, cnt: CNT_W'(1)};

    rf_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_less;
    logic             unused_cnt;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr < REGS_A) begin
                st_d.start[wr_addr[IDX_W-1:0]] = wr_data;
            end else if (wr_addr == BUFCTL_A) begin
                st_d.bufa = wr_data[BUFA_LSB +: BUFA_W];
                st_d.cnt  = (wr_data[CNTF_W-1:0] == '0) ? CNT_MAX
                                                        : CNT_W'(wr_data[CNTF_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // Read-back of the buffer control keeps only the top bit of (count - 1)
    assign cnt_less   = st_q.cnt - CNT_W'(1);
    assign unused_cnt = ^{cnt_less[CNT_W-1], cnt_less[CNTF_W-2:0]};

    always_comb begin
        rd_data = '0;
        if (rd_addr < REGS_A) begin
            rd_data = st_q.start[rd_addr[IDX_W-1:0]];
        end else if (rd_addr == BUFCTL_A) begin
            rd_data[BUFA_LSB +: BUFA_W] = st_q.bufa;
            rd_data[CNTF_W-1]           = cnt_less[CNTF_W-1];
        end
    end

    assign start_regs = st_q.start;
    assign bufa       = st_q.bufa;
    assign cnt        = st_q.cnt;
endmodule

// File: rtl/sag_density.sv
module sag_density
    import sag_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int PAGE_W = DEF_PAGE_W,
    parameter int DENS_W = DEF_DENS_W,
    parameter int BV_W   = blkval_width(DEF_BLK_W, DEF_PAGE_W, DEF_DENS_W)
) (
    input  logic [REG_W-1:0] dev_id,
    output logic [BV_W-1:0]  dmask
);
    logic [31:0] shamt;
    logic        unused_id;

    // Extension flag in bit 3, size selector just above it
    assign shamt     = 32'(PAGE_W) + 32'(dev_id[4 +: DENS_W]);
    assign dmask     = dev_id[3] ? (BV_W'(1) << shamt) : '0;
    assign unused_id = ^{dev_id[REG_W-1:4+DENS_W], dev_id[2:0]};
endmodule

// File: rtl/sag_sector_calc.sv
module sag_sector_calc
    import sag_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int BLK_W  = DEF_BLK_W,
    parameter int PAGE_W = DEF_PAGE_W,
    parameter int SEC_W  = DEF_SEC_W,
    parameter int BV_W   = blkval_width(DEF_BLK_W, DEF_PAGE_W, DEF_DENS_W),
    parameter int SECT_W = BV_W + PAGE_W + SEC_W
) (
    input  logic [REG_W-1:0]  blk_reg,
    input  logic [REG_W-1:0]  pg_reg,
    input  logic [BV_W-1:0]   dmask,
    output logic [BV_W-1:0]   blkval,
    output logic [SECT_W-1:0] sector
);
    logic [PAGE_W-1:0] page_f;
    logic [SEC_W-1:0]  sec_f;
    logic              unused_bits;

    assign blkval = BV_W'(blk_reg[BLK_W-1:0]) | (blk_reg[REG_W-1] ? dmask : '0);
    assign page_f = pg_reg[SEC_W +: PAGE_W];
    assign sec_f  = pg_reg[SEC_W-1:0];
    // Fields are disjoint, so the scaled sum is a plain concatenation
    assign sector = {blkval, page_f, sec_f};

    assign unused_bits = ^{blk_reg[REG_W-2:BLK_W], pg_reg[REG_W-1:SEC_W+PAGE_W]};
endmodule

// File: rtl/sag_buf_decode.sv
module sag_buf_decode
    import sag_pkg::*;
#(
    parameter int BUFA_W   = DEF_BUFA_W,
    parameter int MAIN_SH  = DEF_MAIN_SH,
    parameter int SPARE_SH = DEF_SPARE_SH,
    parameter int OFFS_W   = BUFA_W - 2
) (
    input  logic [BUFA_W-1:0]          bufa,
    output logic                       is_data,
    output logic                       data_sel,
    output logic [OFFS_W+MAIN_SH-1:0]  main_off,
    output logic [OFFS_W+SPARE_SH-1:0] spare_off
);
    assign is_data   = bufa[BUFA_W-1];
    assign data_sel  = bufa[BUFA_W-2];
    assign main_off  = {bufa[OFFS_W-1:0], {MAIN_SH{1'b0}}};
    assign spare_off = {bufa[OFFS_W-1:0], {SPARE_SH{1'b0}}};
endmodule

// File: rtl/sector_addr_gen.sv
module sector_addr_gen
    import sag_pkg::*;
#(
    parameter int REG_W    = DEF_REG_W,
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int BLK_W    = DEF_BLK_W,
    parameter int PAGE_W   = DEF_PAGE_W,
    parameter int SEC_W    = DEF_SEC_W,
    parameter int DENS_W   = DEF_DENS_W,
    parameter int BUFA_W   = DEF_BUFA_W,
    parameter int BUFA_LSB = DEF_BUFA_LSB,
    parameter int MAIN_SH  = DEF_MAIN_SH,
    parameter int SPARE_SH = DEF_SPARE_SH,
    parameter int BV_W     = blkval_width(BLK_W, PAGE_W, DENS_W),
    parameter int SECT_W   = BV_W + PAGE_W + SEC_W,
    parameter int OFFS_W   = BUFA_W - 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [REG_W-1:0]           rd_data,
    input  logic [REG_W-1:0]           dev_id,
    output logic [SECT_W-1:0]          src_sector,
    output logic [SECT_W-1:0]          dst_sector,
    output logic [SECT_W-1:0]          erase_sector,
    output logic [SEC_W:0]             sec_count,
    output logic [BUFA_W-1:0]          buf_addr,
    output logic                       buf_is_data,
    output logic                       buf_data_sel,
    output logic [OFFS_W+MAIN_SH-1:0]  main_offset,
    output logic [OFFS_W+SPARE_SH-1:0] spare_offset
);
    localparam int NUM_PAIRS = 2;

    logic [NUM_REGS-1:0][REG_W-1:0]  start_regs;
    logic [BV_W-1:0]                 dmask;
    logic [NUM_PAIRS-1:0][BV_W-1:0]  bval;
    logic [NUM_PAIRS-1:0][SECT_W-1:0] sect;

    sag_regfile #(
        .REG_W   (REG_W),
        .NUM_REGS(NUM_REGS),
        .ADDR_W  (ADDR_W),
        .BUFA_W  (BUFA_W),
        .BUFA_LSB(BUFA_LSB),
        .CNTF_W  (SEC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .start_regs(start_regs),
        .bufa      (buf_addr),
        .cnt       (sec_count)
    );

    sag_density #(
        .REG_W (REG_W),
        .PAGE_W(PAGE_W),
        .DENS_W(DENS_W),
        .BV_W  (BV_W)
    ) u_dens (
        .dev_id(dev_id),
        .dmask (dmask)
    );

    // Pair 0: source block/page; pair 1: destination block/page
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int BI = (p == 0) ? IDX_SRC_BLOCK : IDX_DST_BLOCK;
        localparam int PI = (p == 0) ? IDX_SRC_PAGE  : IDX_DST_PAGE;
        sag_sector_calc #(
            .REG_W (REG_W),
            .BLK_W (BLK_W),
            .PAGE_W(PAGE_W),
            .SEC_W (SEC_W),
            .BV_W  (BV_W),
            .SECT_W(SECT_W)
        ) u_calc (
            .blk_reg(start_regs[BI]),
            .pg_reg (start_regs[PI]),
            .dmask  (dmask),
            .blkval (bval[p]),
            .sector (sect[p])
        );
    end

    assign src_sector   = sect[0];
    assign dst_sector   = sect[1];
    assign erase_sector = {bval[0], {(PAGE_W + SEC_W){1'b0}}};

    sag_buf_decode #(
        .BUFA_W  (BUFA_W),
        .MAIN_SH (MAIN_SH),
        .SPARE_SH(SPARE_SH),
        .OFFS_W  (OFFS_W)
    ) u_bufdec (
        .bufa     (buf_addr),
        .is_data  (buf_is_data),
        .data_sel (buf_data_sel),
        .main_off (main_offset),
        .spare_off(spare_offset)
    );
endmodule

// File: rtl/sag_checker.sv
module sag_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic [21:0] src_sector,
    input logic [21:0] erase_sector,
    input logic [2:0]  sec_count,
    input logic [3:0]  buf_addr,
    input logic [10:0] main_offset,
    input logic [5:0]  spare_offset
);
    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_count >= 3'd1) && (sec_count <= 3'd4));

    // R7
    count_zero_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd8 && wr_data[1:0] == 2'b00) |=> (sec_count == 3'd4));

    // R7
    bufaddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd8) |=> (buf_addr == $past(wr_data[11:8])));

    // R10
    bufctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 4'd8) |=> ($stable(buf_addr) && $stable(sec_count)));

    // R6
    erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_sector[7:0] == 8'd0) && (erase_sector[21:8] == src_sector[21:8]));

    // R9
    offset_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_offset[10:9] == spare_offset[5:4]) && (main_offset[8:0] == 9'd0)
        && (spare_offset[3:0] == 4'd0));
endmodule

bind sector_addr_gen sag_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .src_sector  (src_sector),
    .erase_sector(erase_sector),
    .sec_count   (sec_count),
    .buf_addr    (buf_addr),
    .main_offset (main_offset),
    .spare_offset(spare_offset)
);

// File: tb/sector_addr_gen_test.sv
`timescale 1ns/1ps
module sector_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] dev_id = '0;
    logic [21:0] src_sector, dst_sector, erase_sector;
    logic [2:0]  sec_count;
    logic [3:0]  buf_addr;
    logic        buf_is_data, buf_data_sel;
    logic [10:0] main_offset;
    logic [5:0]  spare_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sector_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dev_id(dev_id),
        .src_sector(src_sector), .dst_sector(dst_sector), .erase_sector(erase_sector),
        .sec_count(sec_count), .buf_addr(buf_addr), .buf_is_data(buf_is_data),
        .buf_data_sel(buf_data_sel), .main_offset(main_offset), .spare_offset(spare_offset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference values computed straight from the requirement formulas
    function automatic int unsigned ref_blkval(input logic [15:0] b, input logic [15:0] id);
        int unsigned dm;
        dm = id[3] ? (32'd1 << (6 + int'(id[6:4]))) : 32'd0;
        return (int'(b) & 32'hFFF) | (b[15] ? dm : 32'd0);
    endfunction

    function automatic logic [31:0] ref_sector(input logic [15:0] b, input logic [15:0] p,
                                               input logic [15:0] id);
        int unsigned pg, sc;
        pg = (int'(p) >> 2) & 32'h3F;
        sc = int'(p) & 32'h3;
        return (((pg + (ref_blkval(b, id) << 6)) << 2) + sc);
    endfunction

    function automatic logic [31:0] ref_bufctl(input logic [3:0] ba, input int cnt);
        return (32'(ba) << 8) | ((cnt - 1) & 2);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 src_sector", 32'(src_sector), 0);
        check("R1 sec_count", 32'(sec_count), 1);
        check("R1 buf_addr", 32'(buf_addr), 0);
        rd(4'd8, v); check("R1 bufctl read", 32'(v), 0);
        for (int i = 0; i < 8; i++) begin
            rd(4'(i), v); check("R1 start reg read", 32'(v), 0);
        end
    endtask

    task automatic t_regs();
        logic [15:0] v;
        logic [21:0] s0, d0;
        s0 = src_sector; d0 = dst_sector;
        wr(4'd1, 16'hBEEF);
        check("R2 reg1 no src effect", 32'(src_sector), 32'(s0));
        check("R2 reg1 no dst effect", 32'(dst_sector), 32'(d0));
        wr(4'd5, 16'h1234);
        wr(4'd6, 16'hFFFF);
        rd(4'd1, v); check("R2 reg1 read", 32'(v), 32'hBEEF);
        rd(4'd5, v); check("R2 reg5 read", 32'(v), 32'h1234);
        rd(4'd6, v); check("R2 reg6 read", 32'(v), 32'hFFFF);
    endtask

    task automatic t_src_sector();
        dev_id = 16'h0000;
        wr(4'd0, 16'h0ABC);
        wr(4'd7, 16'h00B7);
        check("R3 src basic", 32'(src_sector), ref_sector(16'h0ABC, 16'h00B7, 16'h0));
        wr(4'd7, 16'hFF02);
        check("R3 page high bits ignored", 32'(src_sector), ref_sector(16'h0ABC, 16'h0002, 16'h0));
        wr(4'd0, 16'h7005);
        check("R3 block bits 14:12 ignored", 32'(src_sector), ref_sector(16'h0005, 16'h0002, 16'h0));
        wr(4'd0, 16'h8123);
        check("R4 flag without extension", 32'(src_sector), ref_sector(16'h0123, 16'h0002, 16'h0));
    endtask

    task automatic t_density();
        wr(4'd0, 16'h8001);
        wr(4'd7, 16'h0000);
        dev_id = 16'h0048; #1;
        check("R4 mask bit 10", 32'(src_sector), ref_sector(16'h8001, 16'h0, 16'h0048));
        check("R4 mask bit 10 value", 32'(src_sector), 32'h0401 << 8);
        dev_id = 16'h0078; wr(4'd0, 16'h8FFF);
        check("R4 mask bit 13", 32'(src_sector), 32'h2FFF << 8);
        dev_id = 16'h0008; wr(4'd0, 16'h8040);
        check("R4 mask OR not add", 32'(src_sector), 32'h0040 << 8);
        dev_id = 16'h0078; wr(4'd0, 16'h0011);
        check("R4 no flag no mask", 32'(src_sector), 32'h0011 << 8);
    endtask

    task automatic t_dst_sector();
        dev_id = 16'h0000;
        wr(4'd2, 16'h0010);
        wr(4'd3, 16'h0006);
        check("R5 dst basic", 32'(dst_sector), ref_sector(16'h0010, 16'h0006, 16'h0));
        wr(4'd0, 16'h0FFF);
        wr(4'd7, 16'h00FF);
        check("R5 dst independent of src", 32'(dst_sector), ref_sector(16'h0010, 16'h0006, 16'h0));
        dev_id = 16'h0058;
        wr(4'd2, 16'h8003);
        check("R5 dst density", 32'(dst_sector), ref_sector(16'h8003, 16'h0006, 16'h0058));
    endtask

    task automatic t_erase();
        dev_id = 16'h0000;
        wr(4'd0, 16'h0ABC);
        wr(4'd7, 16'h00FF);
        check("R6 erase sector", 32'(erase_sector), ref_blkval(16'h0ABC, 16'h0) << 8);
        dev_id = 16'h0068; wr(4'd0, 16'h8002);
        check("R6 erase with density", 32'(erase_sector), ref_blkval(16'h8002, 16'h0068) << 8);
    endtask

    task automatic t_bufctl();
        logic [15:0] v;
        wr(4'd8, 16'h0A02);
        check("R7 bufaddr", 32'(buf_addr), 32'hA);
        check("R7 count 2", 32'(sec_count), 2);
        rd(4'd8, v); check("R8 read cnt2", 32'(v), ref_bufctl(4'hA, 2));
        wr(4'd8, 16'h0F00);
        check("R7 count zero means 4", 32'(sec_count), 4);
        rd(4'd8, v); check("R8 read cnt4", 32'(v), ref_bufctl(4'hF, 4));
        wr(4'd8, 16'hF3FD);
        check("R7 other bits ignored bufaddr", 32'(buf_addr), 32'h3);
        check("R7 other bits ignored count", 32'(sec_count), 1);
        rd(4'd8, v); check("R8 read cnt1", 32'(v), ref_bufctl(4'h3, 1));
        wr(4'd8, 16'h0003);
        check("R7 count 3", 32'(sec_count), 3);
        rd(4'd8, v); check("R8 read cnt3", 32'(v), ref_bufctl(4'h0, 3));
    endtask

    task automatic t_bufdecode();
        wr(4'd8, 16'h0E00);
        check("R9 data buffer", 32'(buf_is_data), 1);
        check("R9 data sel 1", 32'(buf_data_sel), 1);
        check("R9 main off 2", 32'(main_offset), 1024);
        check("R9 spare off 2", 32'(spare_offset), 32);
        wr(4'd8, 16'h0500);
        check("R9 boot buffer", 32'(buf_is_data), 0);
        check("R9 sel bit2", 32'(buf_data_sel), 1);
        check("R9 main off 1", 32'(main_offset), 512);
        check("R9 spare off 1", 32'(spare_offset), 16);
        wr(4'd8, 16'h0B00);
        check("R9 data sel 0", 32'(buf_data_sel), 0);
        check("R9 main off 3", 32'(main_offset), 1536);
        check("R9 spare off 3", 32'(spare_offset), 48);
    endtask

    task automatic t_timing();
        // Write is captured at one edge; output must not move before it
        dev_id = 16'h0000;
        wr(4'd0, 16'h0001);
        wr(4'd7, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 16'h0002;
        #1;
        check("R10 before edge", 32'(src_sector), 32'h100);
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 after edge", 32'(src_sector), 32'h200);
        repeat (3) @(negedge clk);
        check("R10 holds", 32'(src_sector), 32'h200);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        logic [21:0] s0, d0;
        logic [3:0]  b0;
        logic [2:0]  c0;
        s0 = src_sector; d0 = dst_sector; b0 = buf_addr; c0 = sec_count;
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 16'hFFFF);
            check("R11 src unchanged", 32'(src_sector), 32'(s0));
            check("R11 dst unchanged", 32'(dst_sector), 32'(d0));
            check("R11 bufaddr unchanged", 32'(buf_addr), 32'(b0));
            check("R11 count unchanged", 32'(sec_count), 32'(c0));
            rd(4'(a), v); check("R11 reads zero", 32'(v), 0);
        end
        rd(4'd0, v); check("R11 reg0 kept", 32'(v), 32'h0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_src_sector();
        t_density();
        t_dst_sector();
        t_erase();
        t_bufctl();
        t_bufdecode();
        t_timing();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule